// File: doc/BRIEF.md
# Flash Bus Interface Front End

This block sits on the device side of a parallel NOR-style flash memory and turns the raw, active-low control pins into a clean per-cycle classification. It samples the chip reset, chip select, output enable, write enable and address-valid pins, the burst clock and a read-mode bit on a faster internal system clock. From these samples it reports which bus operation is in progress, which can be reset, standby, write, output disable, asynchronous read, synchronous read or burst suspend. It then sets the data-bus and WAIT drivers to match that operation.

The block also owns the address latch. In asynchronous mode the latch is transparent while address-valid is low and holds the last address seen when address-valid rises. In synchronous mode it captures once per address-valid window, on whichever comes first: a burst-clock rising edge with address-valid low, or the address-valid rising edge. The partition being accessed is taken from the top bits of the resulting address. Read data from the array comes in on a plain input. Write data and a write-valid level go out toward the command logic.

All decisions are made on registered pin samples, so each output reflects the pins as they stood one system clock earlier.

Top module: `flash_bus_front`

## Requirements
- R1: When the sampled chip reset is low, op_o is 7'b0000001 (bit 0), both dq_oe_o and wait_oe_o are 0, and on the following cycle the latched address and part_o are zero whatever the other pins do.
- R2: With chip reset high and chip select high, op_o is bit 1 (standby), and dq_oe_o and wait_oe_o are 0.
- R3: With chip select low and write enable low, op_o is bit 2 (write), both drivers are off, wr_valid_o is 1, and wr_data_o equals the sampled dq_i. Outside a write, wr_valid_o and wr_data_o are 0.
- R4: With chip select low, write enable high, output enable low and sync_mode_i 0, op_o is bit 4 (async read), dq_oe_o is 1, dq_o equals rd_data_i, wait_oe_o is 1 and wait_o is 0.
- R5: The same pins with sync_mode_i 1 give op_o bit 5 (sync read), with dq_oe_o 1, wait_oe_o 1 and wait_o equal to the inverse of rdy_i.
- R6: The burst clock counts as halted once HALT_CYC system cycles have passed with no rising edge seen on it, and a seen rising edge ends the halted state.
- R7: With chip select low, output and write enable high, sync mode, a halted burst clock and a sync read since the last reset, standby or write, op_o is bit 6 (burst suspend), dq_oe_o stays 1 and wait_oe_o is 0.
- R8: Any other cycle with chip select low and output and write enable high is output disable, op_o bit 3, with both drivers off.
- R9: In async mode, with chip select low and address-valid low, addr_o follows the sampled address, and after address-valid rises it holds the last sampled address.
- R10: In sync mode exactly one capture happens per address-valid low window. It takes the address at the first burst-clock rise with address-valid low, or else the last low-phase address at the address-valid rise. Later edges in the same window leave addr_o unchanged.
- R11: A sync-mode capture happens only while write enable is high and chip select is low.
- R12: part_o always equals the top PART_W bits of addr_o.
- R13: Exactly one bit of op_o is set on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | internal system clock |
| rst_ni | input | 1 | active-low asynchronous block reset |
| dev_rst_ni | input | 1 | chip reset pin, active low |
| chip_sel_ni | input | 1 | chip select pin, active low |
| out_en_ni | input | 1 | output enable pin, active low |
| wr_en_ni | input | 1 | write enable pin, active low |
| addr_vld_ni | input | 1 | address-valid pin, active low |
| bclk_i | input | 1 | burst clock pin |
| sync_mode_i | input | 1 | 1 selects synchronous reads |
| addr_i | input | ADDR_W | address pins |
| dq_i | input | DATA_W | data bus as seen by the input buffers |
| rd_data_i | input | DATA_W | read data from the array |
| rdy_i | input | 1 | array data ready during a burst |
| dq_o | output | DATA_W | data bus output value |
| dq_oe_o | output | 1 | data bus driver enable |
| wait_o | output | 1 | WAIT output value |
| wait_oe_o | output | 1 | WAIT driver enable |
| wr_valid_o | output | 1 | write cycle in progress |
| wr_data_o | output | DATA_W | sampled write data |
| op_o | output | 7 | one-hot bus operation |
| addr_o | output | ADDR_W | effective (latched or flowing) address |
| part_o | output | PART_W | selected partition |

## Verification
The hardest state to reach is burst suspend. It needs a sync read to have occurred first, then output enable raised with write enable still high, and then the burst clock held still for a full halt window, all without a standby, write or reset in between. Random stimulus rarely lines these up. The bench therefore runs random segments in which the burst clock is either toggling or frozen, and it adds a directed sequence that runs a clocked read and then parks the pins until the halt window expires. The one-capture-per-window rule of sync mode is driven the same way, by toggling the burst clock several times inside one address-valid low phase.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int OP_N    = 7;
  localparam int OP_RST  = 0;
  localparam int OP_STBY = 1;
  localparam int OP_WR   = 2;
  localparam int OP_ODIS = 3;
  localparam int OP_ARD  = 4;
  localparam int OP_SRD  = 5;
  localparam int OP_SUSP = 6;
  typedef logic [OP_N-1:0] op_t;
endpackage

// File: rtl/fe_pin_sampler.sv
module fe_pin_sampler #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              adv_ni,
  input  logic              bclk_i,
  input  logic              sync_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              s_rst_no,
  output logic              s_ce_no,
  output logic              s_oe_no,
  output logic              s_we_no,
  output logic              s_adv_no,
  output logic              s_sync_o,
  output logic [ADDR_W-1:0] s_addr_o,
  output logic [DATA_W-1:0] s_dq_o,
  output logic [ADDR_W-1:0] p_addr_o,
  output logic              bclk_rise_o,
  output logic              adv_rise_o
);
  logic s_bclk_q, p_bclk_q, p_adv_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_rst_no <= 1'b0;
      s_ce_no  <= 1'b1;
      s_oe_no  <= 1'b1;
      s_we_no  <= 1'b1;
      s_adv_no <= 1'b1;
      s_sync_o <= 1'b0;
      s_bclk_q <= 1'b0;
      s_addr_o <= '0;
      s_dq_o   <= '0;
      p_bclk_q <= 1'b0;
      p_adv_nq <= 1'b1;
      p_addr_o <= '0;
    end else begin
      s_rst_no <= dev_rst_ni;
      s_ce_no  <= ce_ni;
      s_oe_no  <= oe_ni;
      s_we_no  <= we_ni;
      s_adv_no <= adv_ni;
      s_sync_o <= sync_i;
      s_bclk_q <= bclk_i;
      s_addr_o <= addr_i;
      s_dq_o   <= dq_i;
      p_bclk_q <= s_bclk_q;
      p_adv_nq <= s_adv_no;
      p_addr_o <= s_addr_o;
    end
  end

  assign bclk_rise_o = s_bclk_q & ~p_bclk_q;
  assign adv_rise_o  = s_adv_no & ~p_adv_nq;
endmodule

// File: rtl/fe_halt_det.sv
module fe_halt_det #(
  parameter int HALT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_rise_i,
  output logic halted_o
);
  localparam int CW = $clog2(HALT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HALT_CYC);

  logic [CW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               idle_q <= LIMIT;
    else if (bclk_rise_i)      idle_q <= '0;
    else if (idle_q != LIMIT)  idle_q <= idle_q + 1'b1;
  end

  assign halted_o = (idle_q == LIMIT);

  a_r6_edge_ends_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_rise_i |=> !halted_o);
endmodule

// File: rtl/fe_addr_latch.sv
module fe_addr_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_rst_ni,
  input  logic              s_ce_ni,
  input  logic              s_we_ni,
  input  logic              s_adv_ni,
  input  logic              s_sync_i,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic [ADDR_W-1:0] p_addr_i,
  input  logic              bclk_rise_i,
  input  logic              adv_rise_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] lat_q;
  logic              cap_q;
  logic              gate;

  assign gate = s_we_ni & ~s_ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      cap_q <= 1'b0;
    end else if (!s_rst_ni) begin
      lat_q <= '0;
      cap_q <= 1'b0;
    end else if (!s_sync_i) begin
      if (!s_adv_ni && !s_ce_ni) lat_q <= s_addr_i;
      cap_q <= 1'b0;
    end else if (s_adv_ni) begin
      // rising edge of address-valid: capture only if the clock did not already
      if (adv_rise_i && !cap_q && gate) lat_q <= p_addr_i;
      cap_q <= 1'b0;
    end else if (bclk_rise_i && !cap_q && gate) begin
      lat_q <= s_addr_i;
      cap_q <= 1'b1;
    end
  end

  assign addr_o = (!s_sync_i && !s_adv_ni && !s_ce_ni && s_rst_ni) ? s_addr_i : lat_q;

  a_r1_dev_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_rst_ni |=> (lat_q == '0));
  a_r10_one_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_sync_i && s_rst_ni && !s_adv_ni && cap_q) |=> $stable(lat_q));
  a_r11_gated_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_sync_i && s_rst_ni && !gate) |=> $stable(lat_q));
endmodule

// File: rtl/fe_op_decode.sv
module fe_op_decode
  import flash_fe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_rst_ni,
  input  logic s_ce_ni,
  input  logic s_oe_ni,
  input  logic s_we_ni,
  input  logic s_sync_i,
  input  logic halted_i,
  output op_t  op_o
);
  logic burst_q;

  always_comb begin
    op_o = '0;
    if (!s_rst_ni)                       op_o[OP_RST]  = 1'b1;
    else if (s_ce_ni)                    op_o[OP_STBY] = 1'b1;
    else if (!s_we_ni)                   op_o[OP_WR]   = 1'b1;
    else if (!s_oe_ni && s_sync_i)       op_o[OP_SRD]  = 1'b1;
    else if (!s_oe_ni)                   op_o[OP_ARD]  = 1'b1;
    else if (s_sync_i && halted_i && burst_q) op_o[OP_SUSP] = 1'b1;
    else                                 op_o[OP_ODIS] = 1'b1;
  end

  // a burst stays suspendable until reset, standby or a write ends it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    burst_q <= 1'b0;
    else if (op_o[OP_RST] || op_o[OP_STBY] || op_o[OP_WR]) burst_q <= 1'b0;
    else if (op_o[OP_SRD])                          burst_q <= 1'b1;
  end

  a_r13_onehot_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(op_o) == 1);
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int PART_W   = 3,
  parameter int HALT_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_ni,
  input  logic              chip_sel_ni,
  input  logic              out_en_ni,
  input  logic              wr_en_ni,
  input  logic              addr_vld_ni,
  input  logic              bclk_i,
  input  logic              sync_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rdy_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              wait_o,
  output logic              wait_oe_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [OP_N-1:0]   op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PART_W-1:0] part_o
);
  logic              s_rst_n, s_ce_n, s_oe_n, s_we_n, s_adv_n, s_sync;
  logic [ADDR_W-1:0] s_addr, p_addr;
  logic [DATA_W-1:0] s_dq;
  logic              bclk_rise, adv_rise, halted;
  op_t               op;

  fe_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk_i, .rst_ni,
    .dev_rst_ni, .ce_ni(chip_sel_ni), .oe_ni(out_en_ni), .we_ni(wr_en_ni),
    .adv_ni(addr_vld_ni), .bclk_i, .sync_i(sync_mode_i), .addr_i, .dq_i,
    .s_rst_no(s_rst_n), .s_ce_no(s_ce_n), .s_oe_no(s_oe_n), .s_we_no(s_we_n),
    .s_adv_no(s_adv_n), .s_sync_o(s_sync), .s_addr_o(s_addr), .s_dq_o(s_dq),
    .p_addr_o(p_addr), .bclk_rise_o(bclk_rise), .adv_rise_o(adv_rise)
  );

  fe_halt_det #(.HALT_CYC(HALT_CYC)) u_halt (
    .clk_i, .rst_ni, .bclk_rise_i(bclk_rise), .halted_o(halted)
  );

  fe_addr_latch #(.ADDR_W(ADDR_W)) u_lat (
    .clk_i, .rst_ni,
    .s_rst_ni(s_rst_n), .s_ce_ni(s_ce_n), .s_we_ni(s_we_n), .s_adv_ni(s_adv_n),
    .s_sync_i(s_sync), .s_addr_i(s_addr), .p_addr_i(p_addr),
    .bclk_rise_i(bclk_rise), .adv_rise_i(adv_rise), .addr_o
  );

  fe_op_decode u_dec (
    .clk_i, .rst_ni,
    .s_rst_ni(s_rst_n), .s_ce_ni(s_ce_n), .s_oe_ni(s_oe_n), .s_we_ni(s_we_n),
    .s_sync_i(s_sync), .halted_i(halted), .op_o(op)
  );

  assign op_o       = op;
  assign dq_oe_o    = op[OP_ARD] | op[OP_SRD] | op[OP_SUSP];
  assign dq_o       = dq_oe_o ? rd_data_i : '0;
  assign wait_oe_o  = op[OP_ARD] | op[OP_SRD];
  assign wait_o     = op[OP_SRD] & ~rdy_i;
  assign wr_valid_o = op[OP_WR];
  assign wr_data_o  = op[OP_WR] ? s_dq : '0;
  assign part_o     = addr_o[ADDR_W-1 -: PART_W];

  a_r2_standby_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_o[OP_STBY] |-> (!dq_oe_o && !wait_oe_o));
  a_r4_async_wait_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_o[OP_ARD] |-> (wait_oe_o && !wait_o));
  a_r7_suspend_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_o[OP_SUSP] |-> (dq_oe_o && !wait_oe_o));
  a_r1_reset_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_o[OP_RST] |-> (!dq_oe_o && !wait_oe_o && !wr_valid_o));
endmodule

// File: tb/flash_bus_front_bench.sv
module flash_bus_front_bench;
  localparam int AW = 16, DW = 16, PW = 3, HALT = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic dev_rst_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b1;
  logic bclk = 1'b0, sync = 1'b0, rdy = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq = '0, rd = '0;

  logic [DW-1:0] dq_o, wr_data_o;
  logic          dq_oe_o, wait_o, wait_oe_o, wr_valid_o;
  logic [6:0]    op_o;
  logic [AW-1:0] addr_o;
  logic [PW-1:0] part_o;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  flash_bus_front #(.ADDR_W(AW), .DATA_W(DW), .PART_W(PW), .HALT_CYC(HALT)) u_flash_bus_front (
    .clk_i, .rst_ni, .dev_rst_ni(dev_rst_n), .chip_sel_ni(ce_n), .out_en_ni(oe_n),
    .wr_en_ni(we_n), .addr_vld_ni(adv_n), .bclk_i(bclk), .sync_mode_i(sync),
    .addr_i(addr), .dq_i(dq), .rd_data_i(rd), .rdy_i(rdy),
    .dq_o, .dq_oe_o, .wait_o, .wait_oe_o, .wr_valid_o, .wr_data_o,
    .op_o, .addr_o, .part_o
  );

  // reference model state, built from the requirements
  logic m_rst = 1'b0, m_ce = 1'b1, m_oe = 1'b1, m_we = 1'b1, m_adv = 1'b1, m_bclk = 1'b0, m_sync = 1'b0;
  logic [AW-1:0] m_addr = '0, m_p_addr = '0, m_lat = '0;
  logic [DW-1:0] m_dq = '0;
  logic m_p_bclk = 1'b0, m_p_adv = 1'b1, m_cap = 1'b0, m_burst = 1'b0;
  int   m_idle = HALT;

  function automatic logic [6:0] exp_op();
    logic [6:0] o = '0;
    if (!m_rst)                 o[0] = 1'b1;
    else if (m_ce)              o[1] = 1'b1;
    else if (!m_we)             o[2] = 1'b1;
    else if (!m_oe && m_sync)   o[5] = 1'b1;
    else if (!m_oe)             o[4] = 1'b1;
    else if (m_sync && m_idle == HALT && m_burst) o[6] = 1'b1;
    else                        o[3] = 1'b1;
    return o;
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return (!m_sync && !m_adv && !m_ce && m_rst) ? m_addr : m_lat;
  endfunction

  function automatic string op_tag(input logic [6:0] o);
    if (o[0]) return "R1";
    if (o[1]) return "R2";
    if (o[2]) return "R3";
    if (o[3]) return "R8";
    if (o[4]) return "R4";
    if (o[5]) return "R5";
    return "R7";
  endfunction

  task automatic model_step();
    logic rise = m_bclk & ~m_p_bclk;
    logic [6:0] o = exp_op();
    logic gate = m_we & ~m_ce;
    if (!m_rst) begin m_lat = '0; m_cap = 1'b0; end
    else if (!m_sync) begin
      if (!m_adv && !m_ce) m_lat = m_addr;
      m_cap = 1'b0;
    end else if (m_adv) begin
      if (!m_p_adv && !m_cap && gate) m_lat = m_p_addr;
      m_cap = 1'b0;
    end else if (rise && !m_cap && gate) begin
      m_lat = m_addr; m_cap = 1'b1;
    end
    if (rise) m_idle = 0; else if (m_idle < HALT) m_idle++;
    if (o[0] || o[1] || o[2]) m_burst = 1'b0; else if (o[5]) m_burst = 1'b1;
    m_p_bclk = m_bclk; m_p_adv = m_adv; m_p_addr = m_addr;
    m_rst = dev_rst_n; m_ce = ce_n; m_oe = oe_n; m_we = we_n; m_adv = adv_n;
    m_bclk = bclk; m_sync = sync; m_addr = addr; m_dq = dq;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [6:0] o = exp_op();
    logic       doe = o[4] | o[5] | o[6];
    logic [AW-1:0] a = exp_addr();
    chk(op_o == o, op_tag(o), 32'(op_o), 32'(o));
    chk($countones(op_o) == 1, "R13", 32'(op_o), 32'(o));
    chk(dq_oe_o == doe, op_tag(o), 32'(dq_oe_o), 32'(doe));
    chk(dq_o == (doe ? rd : '0), "R4", 32'(dq_o), 32'(doe ? rd : '0));
    chk(wait_oe_o == (o[4] | o[5]), op_tag(o), 32'(wait_oe_o), 32'(o[4] | o[5]));
    chk(wait_o == (o[5] & ~rdy), "R5", 32'(wait_o), 32'(o[5] & ~rdy));
    chk(wr_valid_o == o[2] && wr_data_o == (o[2] ? m_dq : '0), "R3", 32'(wr_data_o), 32'(o[2] ? m_dq : '0));
    chk(addr_o == a, m_sync ? "R10" : "R9", 32'(addr_o), 32'(a));
    chk(part_o == a[AW-1 -: PW], "R12", 32'(part_o), 32'(a[AW-1 -: PW]));
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic pins(input logic r, c, o, w, a, b, s, input logic [AW-1:0] ad);
    dev_rst_n = r; ce_n = c; oe_n = o; we_n = w; adv_n = a; bclk = b; sync = s; addr = ad;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state while block reset is held
    compare_all();
    chk(op_o == 7'b0000001 && addr_o == '0, "R1", 32'(op_o), 32'h1);
    rst_ni = 1'b1;

    // R9 async flow-through then hold at rising address-valid
    pins(1, 0, 0, 1, 0, 0, 0, 16'h1234); tick(); tick();
    chk(addr_o == 16'h1234, "R9", 32'(addr_o), 32'h1234);
    addr = 16'hA5A5; tick();
    chk(addr_o == 16'hA5A5 && part_o == 3'b101, "R9", 32'(addr_o), 32'hA5A5);
    adv_n = 1'b1; addr = 16'h0F0F; tick(); tick();
    chk(addr_o == 16'hA5A5, "R9", 32'(addr_o), 32'hA5A5);

    // R10 sync capture on first burst-clock rise, later rises ignored
    pins(1, 0, 0, 1, 0, 0, 1, 16'hC001); tick();
    bclk = 1'b1; tick();
    addr = 16'hC002; tick();
    chk(addr_o == 16'hC001, "R10", 32'(addr_o), 32'hC001);
    bclk = 1'b0; tick(); bclk = 1'b1; tick(); tick();
    chk(addr_o == 16'hC001, "R10", 32'(addr_o), 32'hC001);
    adv_n = 1'b1; tick(); tick();
    chk(addr_o == 16'hC001, "R10", 32'(addr_o), 32'hC001);

    // R10 capture at address-valid rise with the clock frozen
    pins(1, 0, 0, 1, 0, 1, 1, 16'h7E11); tick(); tick();
    adv_n = 1'b1; addr = 16'h0000; tick(); tick();
    chk(addr_o == 16'h7E11, "R10", 32'(addr_o), 32'h7E11);

    // R11 no capture while write enable is low
    pins(1, 0, 1, 0, 0, 0, 1, 16'hBEEF); dq = 16'h5AA5; tick();
    chk(wr_valid_o && wr_data_o == 16'h5AA5, "R3", 32'(wr_data_o), 32'h5AA5);
    bclk = 1'b1; tick(); tick(); adv_n = 1'b1; tick(); tick();
    chk(addr_o == 16'h7E11, "R11", 32'(addr_o), 32'h7E11);

    // R6 / R7 burst suspend after the halt window
    pins(1, 0, 0, 1, 1, 0, 1, 16'h4000);
    for (int i = 0; i < 6; i++) begin bclk = ~bclk; rdy = i[0]; tick(); end
    oe_n = 1'b1; tick();
    chk(op_o == 7'b0001000, "R8", 32'(op_o), 32'h8);
    repeat (HALT + 2) tick();
    chk(op_o == 7'b1000000 && dq_oe_o && !wait_oe_o, "R6", 32'(op_o), 32'h40);

    // R1 chip reset pin clears latch
    dev_rst_n = 1'b0; tick(); tick();
    chk(addr_o == '0 && part_o == '0, "R1", 32'(addr_o), 32'h0);
    pins(1, 1, 1, 1, 1, 0, 0, 16'h0); tick();
    chk(op_o == 7'b0000010, "R2", 32'(op_o), 32'h2);

    // constrained random segments
    for (int seg = 0; seg < 400; seg++) begin
      bit run = $urandom_range(1, 0) == 1;
      int len = $urandom_range(HALT + 4, 2);
      if ($urandom_range(7, 0) == 0) sync = ~sync;
      for (int k = 0; k < len; k++) begin
        dev_rst_n = $urandom_range(29, 0) != 0;
        ce_n  = $urandom_range(5, 0) == 0;
        oe_n  = $urandom_range(1, 0) == 1;
        we_n  = $urandom_range(4, 0) != 0;
        if ($urandom_range(2, 0) == 0) adv_n = ~adv_n;
        if (run) bclk = ~bclk;
        addr = 16'($urandom);
        dq   = 16'($urandom);
        rd   = 16'($urandom);
        rdy  = $urandom_range(1, 0) == 1;
        tick();
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule